// File: doc/BRIEF.md
# Parallel EPROM Read Sequencer

This block is a synchronous controller on the host side. It fetches single bytes from an asynchronous parallel EPROM that has two active-low controls. The first is a select line (`mem_e_n`), which also switches the device between active and low-power standby. The second is a read strobe (`mem_g_n`), which gates the device's data onto the shared bus. A client raises `req` with an address while `ready` is high. The controller registers the address and puts it on `mem_addr`. In the same cycle it drops the select, because the device's delay from address to data is the same as its delay from select to data. It drops the strobe later, at an offset chosen so that both the access delay and the strobe-to-data delay end together. It then captures the byte and returns it with a single-cycle `rd_valid`.

Both device delays are parameters given in nanoseconds. They are converted to clock cycles by rounding up at the configured clock period, so one RTL source covers several speed grades. At the end of each access the strobe is released first and the select one cycle later. The controller then spends one full cycle with the select high, leaving the device in standby, before it accepts the next request.

Top module: `eprom_read_ctrl`

## Requirements
- R1: While reset is held, and right after it, `ready` is 1, `mem_e_n` and `mem_g_n` are 1 and `rd_valid` is 0.
- R2: The access delay in cycles is ACC = ceil(T_ACC_NS / CLK_NS). The strobe delay in cycles is OE = ceil(T_OE_NS / CLK_NS). TOT is the larger of the two, and at least 1.
- R3: The cycle after a request is accepted, `mem_e_n` goes to 0 and stays 0 for exactly TOT+2 cycles. `mem_g_n` goes to 0 GS cycles after `mem_e_n`, where GS = max(ACC-OE, 0), and stays 0 for TOT+1-GS cycles.
- R4: `mem_addr` carries the accepted address and does not change while `mem_e_n` is 0.
- R5: The data bus is captured at the clock edge that ends the (TOT+1)-th cycle of `mem_e_n` low. `rd_valid` is 1 for exactly one cycle, TOT+2 cycles after the accepting edge, with the captured byte on `rd_data`.
- R6: In the cycle that `rd_valid` is 1, `mem_g_n` is already 1 and `mem_e_n` is still 0. `mem_e_n` returns to 1 in the next cycle.
- R7: `ready` is 0 from the accepting edge through the first cycle in which `mem_e_n` is 1 again. It returns to 1 in the cycle after that.
- R8: A request made while `ready` is 0 is ignored. It does not change `mem_addr`, start a second access or produce an extra `rd_valid`.
- R9: `mem_g_n` is never 0 while `mem_e_n` is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | 1 | Read request, taken when `ready` is 1 |
| req_addr | input | ADDR_W | Byte address of the request |
| ready | output | 1 | Controller can accept a request |
| rd_valid | output | 1 | One-cycle pulse marking `rd_data` |
| rd_data | output | DATA_W | Byte read from the device |
| mem_addr | output | ADDR_W | Address lines to the device |
| mem_e_n | output | 1 | Device select / power control, active low |
| mem_g_n | output | 1 | Device read strobe, active low |
| mem_data | input | DATA_W | Data bus from the device |

## Verification
The bench builds two copies of the block at an 8 ns clock. The first uses a 100/50 ns grade, which gives ACC=13 and OE=7. There the access delay dominates and the strobe starts at offset 6, so both windows end on the same cycle with no slack. The second uses 20/30 ns, which gives ACC=3 and OE=4. There the strobe delay dominates, so the strobe must fall in the same cycle as the select (GS=0). A bench model of the device puts the inverse of the correct byte on the bus until both delays have elapsed. A capture even one cycle early therefore shows up as wrong data on both copies.

// File: rtl/eprom_read_ctrl.sv
module eprom_read_ctrl #(
  parameter int ADDR_W   = 19,
  parameter int DATA_W   = 8,
  parameter int CLK_NS   = 8,
  parameter int T_ACC_NS = 100,
  parameter int T_OE_NS  = 50
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              ready,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_e_n,
  output logic              mem_g_n,
  input  logic [DATA_W-1:0] mem_data
);
  localparam int ACC_CYC = (T_ACC_NS + CLK_NS - 1) / CLK_NS;
  localparam int OE_CYC  = (T_OE_NS + CLK_NS - 1) / CLK_NS;
  localparam int G_START = (ACC_CYC > OE_CYC) ? ACC_CYC - OE_CYC : 0;
  localparam int T_MAX   = (ACC_CYC > OE_CYC) ? ACC_CYC : OE_CYC;
  localparam int T_TOT   = (T_MAX < 1) ? 1 : T_MAX;
  localparam int CNT_W   = $clog2(T_TOT + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(T_TOT);

  typedef enum logic [1:0] {S_IDLE, S_ACC, S_REL, S_GAP} state_t;

  state_t           st;
  logic [CNT_W-1:0] cnt;
  logic             g_on;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      cnt      <= '0;
      mem_addr <= '0;
      rd_data  <= '0;
      rd_valid <= 1'b0;
    end else begin
      rd_valid <= 1'b0;
      case (st)
        S_IDLE: if (req) begin
          mem_addr <= req_addr;
          cnt      <= '0;
          st       <= S_ACC;
        end
        S_ACC: if (cnt == LAST) begin
          rd_data  <= mem_data;
          rd_valid <= 1'b1;
          st       <= S_REL;
        end else begin
          cnt <= cnt + 1'b1;
        end
        S_REL:   st <= S_GAP;
        default: st <= S_IDLE;
      endcase
    end
  end

  generate
    if (G_START == 0) begin : g_with_e
      assign g_on = (st == S_ACC);
    end else begin : g_delayed
      assign g_on = (st == S_ACC) && (cnt >= CNT_W'(G_START));
    end
  endgenerate

  assign ready   = (st == S_IDLE);
  assign mem_e_n = !((st == S_ACC) || (st == S_REL));
  assign mem_g_n = !g_on;
endmodule

// File: rtl/eprom_read_ctrl_chk.sv
module eprom_read_ctrl_chk #(
  parameter int ADDR_W = 19
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ready,
  input logic              rd_valid,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              mem_e_n,
  input logic              mem_g_n
);
  a_r9_strobe_inside_select: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_g_n |-> !mem_e_n);

  a_r5_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |=> !rd_valid);

  a_r5_capture_under_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> $past(!mem_g_n));

  a_r6_strobe_first: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> (mem_g_n && !mem_e_n));

  a_r6_select_follows: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |=> mem_e_n);

  a_r7_gap_not_ready: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_e_n) |-> !ready);

  a_r7_busy_not_ready: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_e_n |-> !ready);

  a_r4_addr_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_e_n && $past(!mem_e_n)) |-> $stable(mem_addr));
endmodule

bind eprom_read_ctrl eprom_read_ctrl_chk #(.ADDR_W(ADDR_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .ready(ready), .rd_valid(rd_valid),
  .mem_addr(mem_addr), .mem_e_n(mem_e_n), .mem_g_n(mem_g_n)
);

// File: tb/eprom_read_ctrl_tb_top.sv
module eprom_read_ctrl_lane #(
  parameter int T_ACC_NS = 100,
  parameter int T_OE_NS  = 50,
  parameter int SEED     = 1,
  parameter int NREADS   = 40
) (
  input  logic clk,
  input  logic rst_n,
  output int   checks,
  output int   errors,
  output logic done
);
  localparam int CLK_NS = 8;
  localparam int AW = 19;
  localparam int ACC = (T_ACC_NS + CLK_NS - 1) / CLK_NS;
  localparam int OE  = (T_OE_NS + CLK_NS - 1) / CLK_NS;
  localparam int GS  = (ACC > OE) ? ACC - OE : 0;
  localparam int TOT = (ACC > OE) ? ACC : OE;

  logic          req = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic          ready, rd_valid, e_n, g_n;
  logic [7:0]    rd_data;
  logic [AW-1:0] mem_addr;
  wire  [7:0]    bus;

  function automatic logic [7:0] rom(input logic [AW-1:0] a);
    return a[7:0] ^ a[15:8] ^ {a[18:16], 5'b10101} ^ 8'h3C;
  endfunction

  int            ecnt = 0, gcnt = 0;
  logic          e_q = 1'b1;
  logic [AW-1:0] addr_q = '0;
  always @(posedge clk) begin
    if (e_n || (!e_q && mem_addr != addr_q)) ecnt <= 0; else ecnt <= ecnt + 1;
    if (g_n) gcnt <= 0; else gcnt <= gcnt + 1;
    e_q    <= e_n;
    addr_q <= mem_addr;
  end
  assign bus = (!e_n && !g_n) ? ((ecnt >= ACC && gcnt >= OE) ? rom(mem_addr) : ~rom(mem_addr)) : 8'bz;

  eprom_read_ctrl #(.ADDR_W(AW), .DATA_W(8), .CLK_NS(CLK_NS),
                    .T_ACC_NS(T_ACC_NS), .T_OE_NS(T_OE_NS)) dut_i (
    .clk(clk), .rst_n(rst_n), .req(req), .req_addr(req_addr), .ready(ready),
    .rd_valid(rd_valid), .rd_data(rd_data), .mem_addr(mem_addr),
    .mem_e_n(e_n), .mem_g_n(g_n), .mem_data(bus));

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s (acc %0d ns) actual=%0h expected=%0h", tag, T_ACC_NS, act, exp);
    end
  endtask

  task automatic do_read(input logic [AW-1:0] a, input bit pile);
    int  n, elow, glow;
    bit  addr_ok, eg_ok;
    chk(ready == 1'b1, "R7 ready before request", int'(ready), 1);
    req = 1'b1;
    req_addr = a;
    @(posedge clk);
    @(negedge clk);
    if (pile) req_addr = ~a; else req = 1'b0;
    n = 1; elow = 0; glow = 0; addr_ok = 1; eg_ok = 1;
    chk(e_n == 1'b0, "R3 select with address", int'(e_n), 0);
    chk(g_n == (GS != 0), "R3 strobe start", int'(g_n), int'(GS != 0));
    forever begin
      if (!e_n) elow++;
      if (!g_n) glow++;
      if (!g_n && e_n) eg_ok = 0;
      if (mem_addr !== a) addr_ok = 0;
      if (rd_valid || n > TOT + 4) break;
      @(negedge clk);
      n++;
    end
    chk(n == TOT + 2, "R2/R5 latency", n, TOT + 2);
    chk(rd_data == rom(a), "R5 data", int'(rd_data), int'(rom(a)));
    chk(g_n == 1'b1 && e_n == 1'b0, "R6 strobe released first", int'({g_n, e_n}), 2);
    chk(elow == TOT + 2, "R3 select width", elow, TOT + 2);
    chk(glow == TOT + 1 - GS, "R3 strobe width", glow, TOT + 1 - GS);
    chk(addr_ok, "R4 address hold", int'(addr_ok), 1);
    chk(eg_ok, "R9 no strobe in standby", int'(eg_ok), 1);
    @(negedge clk);
    chk(rd_valid == 1'b0, "R5 pulse width", int'(rd_valid), 0);
    chk(e_n == 1'b1 && ready == 1'b0, "R6/R7 standby gap", int'({e_n, ready}), 2);
    @(negedge clk);
    chk(ready == 1'b1 && e_n == 1'b1, "R7 ready after gap", int'({ready, e_n}), 3);
    chk(rd_valid == 1'b0 && mem_addr == a, "R8 held request ignored",
        int'(mem_addr), int'(a));
    req = 1'b0;
  endtask

  initial begin
    checks = 0;
    errors = 0;
    done = 1'b0;
    void'($urandom(SEED));
    @(negedge clk);
    chk({ready, e_n, g_n, rd_valid} == 4'b1110, "R1 reset state",
        int'({ready, e_n, g_n, rd_valid}), 14);
    wait (rst_n == 1'b1);
    @(negedge clk);
    chk({ready, e_n, g_n, rd_valid} == 4'b1110, "R1 after reset",
        int'({ready, e_n, g_n, rd_valid}), 14);
    do_read('0, 1'b0);
    do_read('1, 1'b0);
    do_read(19'h2A5C3, 1'b1);
    do_read(19'h00001, 1'b1);
    for (int i = 0; i < NREADS; i++) begin
      int gap;
      gap = int'($urandom % 4);
      for (int k = 0; k < gap; k++) @(negedge clk);
      do_read(AW'($urandom), ($urandom % 3) == 0);
    end
    done = 1'b1;
  end
endmodule

module eprom_read_ctrl_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  int   ca, ea, cb, eb;
  logic da, db;
  int   cycles = 0;

  always #4 clk = ~clk;

  eprom_read_ctrl_lane #(.T_ACC_NS(100), .T_OE_NS(50), .SEED(11), .NREADS(40)) lane_slow (
    .clk(clk), .rst_n(rst_n), .checks(ca), .errors(ea), .done(da));
  eprom_read_ctrl_lane #(.T_ACC_NS(20), .T_OE_NS(30), .SEED(23), .NREADS(60)) lane_fast (
    .clk(clk), .rst_n(rst_n), .checks(cb), .errors(eb), .done(db));

  initial begin
    int wd_err;
    wd_err = 0;
    repeat (5) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    while (!(da && db) && cycles < 100000) begin
      @(posedge clk);
      cycles++;
    end
    if (!(da && db)) begin
      wd_err = 1;
      $display("FAIL watchdog actual=%0d expected=done", cycles);
    end
    $display("CHECKS %0d ERRORS %0d", ca + cb + wd_err, ea + eb + wd_err);
    $finish;
  end
endmodule